// File: doc/BRIEF.md
# Media-Independent Interface Transmit Nibble Serializer

This block sits on the MAC side of a 4-bit media-independent interface and turns a byte-wide frame stream into the nibble stream the PHY expects. Bytes arrive over a valid/ready handshake with an end-of-frame marker. Each byte goes out over two cycles of the PHY-supplied transmit clock, with the frame-enable line held for the whole frame. The block never needs to know the link speed, because every output is a register clocked by that transmit clock.

Two out-of-band behaviours sit on top of plain transmission. An abort request, or a starved input in the middle of a frame, corrupts the frame on the wire: the error line is raised for one cycle while the enable line is still high. The frame then ends, and the rest of its bytes are swallowed. Between frames, a low-power-idle request replaces the quiet idle pattern with a fixed code, with the error line high and the enable line low. A new frame cannot start while that request is held.

Top module: `mii_tx_serializer`

## Requirements
- R1: While rst_n is low (synchronous, active low) at a clock edge, txd, tx_en and tx_er are all zero after that edge, and in_ready is low.
- R2: Each byte is sent as two consecutive nibbles on txd, first bits [3:0] and then bits [7:4].
- R3: tx_en is high for exactly 2*N consecutive cycles for an N-byte frame, and it drops for at least one cycle between back-to-back frames.
- R4: During a frame, in_ready is high only in the cycle whose closing edge loads the high nibble of the current byte, so one byte is accepted every two cycles and never in two adjacent cycles.
- R5: An abort_req sampled high during a frame produces exactly one cycle with tx_en=1, tx_er=1 and txd=0, and tx_en is low in the following cycle.
- R6: After an abort, the remaining bytes of that frame, up to and including the one marked in_last, are accepted with tx_en kept low. The next frame then starts normally.
- R7: If in_valid is low when the next byte of an unfinished frame is needed, the block reacts as it does to an abort (R5, R6).
- R8: While lpi_req is high and no frame is active, the outputs are held at tx_en=0, tx_er=1, txd=4'b0001.
- R9: No frame starts while lpi_req is high. A low-power-idle request made during a frame takes effect only after tx_en has been low for at least one cycle.
- R10: Outside a frame, and with no low-power-idle request, tx_er is low. An abort_req outside a frame has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tx_clk | input | 1 | Free-running transmit clock from the PHY |
| rst_n | input | 1 | Synchronous active-low reset |
| in_data | input | 8 | Byte to transmit, held until accepted |
| in_valid | input | 1 | in_data holds a byte |
| in_last | input | 1 | The byte is the final one of its frame |
| in_ready | output | 1 | The byte is consumed at the next edge when in_valid is high |
| abort_req | input | 1 | Corrupt and end the frame in flight |
| lpi_req | input | 1 | Request low-power-idle signalling between frames |
| txd | output | 4 | Transmit nibble to the PHY |
| tx_en | output | 1 | Frame enable to the PHY |
| tx_er | output | 1 | Error / out-of-band signalling to the PHY |

## Verification
The bench aims an abort at a single-byte frame whose end marker is accepted in the same cycle. A design that drains there wrongly would swallow the next frame, and the scoreboard would see missing nibbles. It starves the input after a non-final byte. A design that stalls instead of corrupting would hold tx_en high without the error pulse, or would send the late bytes as data. It holds lpi_req while a byte is waiting, and raises it in the middle of a frame. A design with the wrong priority would start a frame under the low-power code, cut the frame short, or put out the code straight after tx_en with no quiet cycle. Back-to-back frames and frame lengths are also counted, to catch a merged frame or a broken nibble order.

// File: rtl/mii_tx_pkg.sv
// Shared types for the transmit nibble serializer.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package mii_tx_pkg;

    // Sequencer states.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEND,
        ST_ERR,
        ST_DRAIN,
        ST_LPI
    } tx_state_e;

    // What the output stage loads at the coming edge.
    typedef enum logic [1:0] {
        OUT_QUIET,
        OUT_DATA,
        OUT_ABORT,
        OUT_LPI
    } out_cmd_e;

endpackage

// File: rtl/mii_tx_ctrl.sv
// Frame sequencer: walks nibbles of each byte, handles abort, underrun,
// draining of an aborted frame and low-power-idle entry and exit.
// Assumes: NIBS >= 2; in_data/in_last stay stable while in_valid is high
// and the byte is not yet accepted.
module mii_tx_ctrl
    import mii_tx_pkg::*;
#(
    parameter int NIBS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 in_last,
    input  logic                 abort_req,
    input  logic                 lpi_req,
    output logic                 in_ready,
    output out_cmd_e             cmd,
    output logic [$clog2(NIBS)-1:0] sel
);

    localparam int IDX_W = $clog2(NIBS);
    localparam logic [IDX_W-1:0] IDX_ACC = IDX_W'(NIBS - 2);
    localparam logic [IDX_W-1:0] IDX_END = IDX_W'(NIBS - 1);

    tx_state_e        state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             last_q, last_d;
    logic             drain_q, drain_d;

    // Byte is taken on the edge that loads its final nibble, or while draining.
    assign in_ready = ((state_q == ST_SEND) && (idx_q == IDX_ACC)) ||
                      (state_q == ST_DRAIN);

    // Next-state and output-command decode.
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        last_d  = last_q;
        drain_d = drain_q;
        cmd     = OUT_QUIET;
        sel     = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (lpi_req) begin
                    state_d = ST_LPI;
                    cmd     = OUT_LPI;
                end else if (in_valid) begin
                    state_d = ST_SEND;
                    idx_d   = '0;
                    last_d  = 1'b0;
                    cmd     = OUT_DATA;
                    sel     = '0;
                end
            end
            ST_SEND: begin
                if (idx_q == IDX_ACC) begin
                    last_d = in_last;
                end
                if (abort_req) begin
                    state_d = ST_ERR;
                    cmd     = OUT_ABORT;
                    if (idx_q == IDX_ACC) begin
                        drain_d = !in_last;
                    end else if (idx_q == IDX_END) begin
                        drain_d = !last_q;
                    end else begin
                        drain_d = 1'b1;
                    end
                end else if (idx_q != IDX_END) begin
                    idx_d = IDX_W'(idx_q + 1'b1);
                    cmd   = OUT_DATA;
                    sel   = IDX_W'(idx_q + 1'b1);
                end else if (last_q) begin
                    state_d = ST_IDLE;
                end else if (in_valid) begin
                    idx_d = '0;
                    cmd   = OUT_DATA;
                    sel   = '0;
                end else begin
                    state_d = ST_ERR;
                    cmd     = OUT_ABORT;
                    drain_d = 1'b1;
                end
            end
            ST_ERR: begin
                state_d = drain_q ? ST_DRAIN : ST_IDLE;
            end
            ST_DRAIN: begin
                if (in_valid && in_last) begin
                    state_d = ST_IDLE;
                end
            end
            ST_LPI: begin
                if (lpi_req) begin
                    cmd = OUT_LPI;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Sequencer registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            last_q  <= 1'b0;
            drain_q <= 1'b0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            last_q  <= last_d;
            drain_q <= drain_d;
        end
    end

endmodule

// File: rtl/mii_tx_outreg.sv
// Output stage: registers txd/tx_en/tx_er from the sequencer command, so
// every pin changes only on the transmit clock edge.
// Assumes: sel < DATA_W/NIB_W when cmd is OUT_DATA.
module mii_tx_outreg
    import mii_tx_pkg::*;
#(
    parameter int               DATA_W   = 8,
    parameter int               NIB_W    = 4,
    parameter logic [NIB_W-1:0] LPI_CODE = 4'b0001
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  out_cmd_e                       cmd,
    input  logic [$clog2(DATA_W/NIB_W)-1:0] sel,
    input  logic [DATA_W-1:0]              in_data,
    output logic [NIB_W-1:0]               txd,
    output logic                           tx_en,
    output logic                           tx_er
);

    localparam int NIBS = DATA_W / NIB_W;

    logic [NIB_W-1:0] nib [NIBS];

    // Slice the byte into nibbles, lowest bits first.
    for (genvar g = 0; g < NIBS; g++) begin : g_slice
        assign nib[g] = in_data[g*NIB_W +: NIB_W];
    end

    // Load the pin values chosen by the sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txd   <= '0;
            tx_en <= 1'b0;
            tx_er <= 1'b0;
        end else begin
            unique case (cmd)
                OUT_DATA: begin
                    txd   <= nib[sel];
                    tx_en <= 1'b1;
                    tx_er <= 1'b0;
                end
                OUT_ABORT: begin
                    txd   <= '0;
                    tx_en <= 1'b1;
                    tx_er <= 1'b1;
                end
                OUT_LPI: begin
                    txd   <= LPI_CODE;
                    tx_en <= 1'b0;
                    tx_er <= 1'b1;
                end
                default: begin
                    txd   <= '0;
                    tx_en <= 1'b0;
                    tx_er <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/mii_tx_serializer.sv
// Top of the transmit nibble serializer: sequencer plus output register.
// Assumes: tx_clk is the PHY transmit clock; all inputs are synchronous to it.
module mii_tx_serializer
    import mii_tx_pkg::*;
#(
    parameter int               DATA_W   = 8,
    parameter int               NIB_W    = 4,
    parameter logic [NIB_W-1:0] LPI_CODE = 4'b0001
) (
    input  logic              tx_clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              in_last,
    output logic              in_ready,
    input  logic              abort_req,
    input  logic              lpi_req,
    output logic [NIB_W-1:0]  txd,
    output logic              tx_en,
    output logic              tx_er
);

    localparam int NIBS  = DATA_W / NIB_W;
    localparam int IDX_W = $clog2(NIBS);

    out_cmd_e         cmd;
    logic [IDX_W-1:0] sel;

    mii_tx_ctrl #(.NIBS(NIBS)) u_ctrl (
        .clk       (tx_clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_last   (in_last),
        .abort_req (abort_req),
        .lpi_req   (lpi_req),
        .in_ready  (in_ready),
        .cmd       (cmd),
        .sel       (sel)
    );

    mii_tx_outreg #(
        .DATA_W   (DATA_W),
        .NIB_W    (NIB_W),
        .LPI_CODE (LPI_CODE)
    ) u_out (
        .clk     (tx_clk),
        .rst_n   (rst_n),
        .cmd     (cmd),
        .sel     (sel),
        .in_data (in_data),
        .txd     (txd),
        .tx_en   (tx_en),
        .tx_er   (tx_er)
    );

endmodule

// File: rtl/mii_tx_serializer_chk.sv
// Protocol checker bound to the serializer top; observes ports only.
module mii_tx_serializer_chk #(
    parameter int               NIB_W    = 4,
    parameter logic [NIB_W-1:0] LPI_CODE = 4'b0001
) (
    input logic             tx_clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             lpi_req,
    input logic [NIB_W-1:0] txd,
    input logic             tx_en,
    input logic             tx_er
);

    // R4: no byte accepted in two adjacent frame cycles.
    assert_accept_spacing_R4: assert property (@(posedge tx_clk) disable iff (!rst_n)
        (in_valid && in_ready && tx_en && !tx_er) |=> !in_ready);

    // R5: the corrupting cycle is followed by enable low.
    assert_abort_ends_R5: assert property (@(posedge tx_clk) disable iff (!rst_n)
        (tx_en && tx_er) |=> !tx_en);

    // R8: out-of-frame error signalling always carries the low-power code.
    assert_lpi_code_R8: assert property (@(posedge tx_clk) disable iff (!rst_n)
        (tx_er && !tx_en) |-> (txd == LPI_CODE));

    // R9: no frame begins under a low-power request.
    assert_no_start_in_lpi_R9: assert property (@(posedge tx_clk) disable iff (!rst_n)
        $rose(tx_en) |-> !$past(lpi_req));

    // R9: low-power code only after a cycle with enable low.
    assert_lpi_gap_R9: assert property (@(posedge tx_clk) disable iff (!rst_n)
        (tx_er && !tx_en && !$past(tx_er)) |-> !$past(tx_en));

    // R10: quiet idle keeps the error line low.
    assert_quiet_idle_R10: assert property (@(posedge tx_clk) disable iff (!rst_n)
        (!$past(lpi_req) && !$past(tx_en) && !tx_en) |-> !tx_er);

endmodule

bind mii_tx_serializer mii_tx_serializer_chk #(
    .NIB_W    (NIB_W),
    .LPI_CODE (LPI_CODE)
) u_chk (
    .tx_clk   (tx_clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .lpi_req  (lpi_req),
    .txd      (txd),
    .tx_en    (tx_en),
    .tx_er    (tx_er)
);

// File: tb/mii_tx_serializer_tb.sv
// Scoreboard bench for the transmit nibble serializer.
module mii_tx_serializer_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_valid = 1'b0;
    logic       in_last = 1'b0;
    logic       in_ready;
    logic       abort_req = 1'b0;
    logic       lpi_req = 1'b0;
    logic [3:0] txd;
    logic       tx_en;
    logic       tx_er;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int acc_cyc = 0;
    int acc_prev = 0;
    bit done = 1'b0;
    bit sb_en = 1'b1;
    logic [3:0] expq [$];

    int run = 0;
    int last_len = 0;
    int frames = 0;
    int err_cnt = 0;
    int en_after_err = 0;
    int en_total = 0;
    int lpi_viol = 0;
    bit prev_en = 1'b0;
    bit prev_err = 1'b0;
    bit prev_lpi = 1'b0;

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    mii_tx_serializer u_dut (
        .tx_clk    (clk),
        .rst_n     (rst_n),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .in_last   (in_last),
        .in_ready  (in_ready),
        .abort_req (abort_req),
        .lpi_req   (lpi_req),
        .txd       (txd),
        .tx_en     (tx_en),
        .tx_er     (tx_er)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: pops expected nibbles and keeps frame statistics.
    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_en && !tx_er && sb_en) begin
                total++;
                if (expq.size() == 0) begin
                    bad++;
                    $display("FAIL R2 actual=%0d expected=none", txd);
                end else begin
                    logic [3:0] e;
                    e = expq.pop_front();
                    if (txd !== e) begin
                        bad++;
                        $display("FAIL R2 actual=%0d expected=%0d", txd, e);
                    end
                end
            end
            if (tx_en) begin
                run++;
                en_total++;
            end else if (run > 0) begin
                last_len = run;
                frames++;
                run = 0;
            end
            if (tx_en && tx_er) err_cnt++;
            if (prev_err && tx_en) en_after_err++;
            if (tx_er && !tx_en && !prev_lpi && prev_en) lpi_viol++;
            if (tx_er && !tx_en && txd != 4'h1) lpi_viol++;
            prev_en  = tx_en;
            prev_err = tx_en && tx_er;
            prev_lpi = tx_er && !tx_en;
        end
    end

    // Driver: offers one byte and waits for its acceptance.
    task automatic send_byte(input logic [7:0] d, input bit last, input bit push);
        in_data  = d;
        in_last  = last;
        in_valid = 1'b1;
        if (push) begin
            expq.push_back(d[3:0]);
            expq.push_back(d[7:4]);
        end
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        acc_prev = acc_cyc;
        acc_cyc  = cyc;
        #1;
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic send_frame(input int n, input logic [7:0] base, input bit push);
        for (int i = 0; i < n; i++) begin
            send_byte(base + 8'(i * 8'h37), i == n - 1, push);
            if (push && i > 0) check(acc_cyc - acc_prev == 2, "R4", acc_cyc - acc_prev, 2);
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        int e0;
        int n0;
        repeat (3) @(negedge clk);
        check(txd == 0 && !tx_en && !tx_er, "R1", {txd, tx_en, tx_er}, 0);
        check(!in_ready, "R1", in_ready, 0);
        @(posedge clk); #1 rst_n = 1'b1;

        // Basic three-byte frame.
        send_frame(3, 8'hA5, 1);
        settle();
        check(last_len == 6, "R3", last_len, 6);
        check(expq.size() == 0, "R2", expq.size(), 0);

        // Single byte frame.
        send_frame(1, 8'h3C, 1);
        settle();
        check(last_len == 2, "R3", last_len, 2);

        // Back-to-back frames must stay separate.
        n0 = frames;
        send_frame(2, 8'h12, 1);
        send_frame(2, 8'hE7, 1);
        settle();
        check(frames - n0 == 2, "R3", frames - n0, 2);
        check(last_len == 4, "R3", last_len, 4);

        // Abort while idle is ignored.
        @(negedge clk); abort_req = 1'b1;
        repeat (2) @(negedge clk);
        check(!tx_er && !tx_en, "R10", {tx_en, tx_er}, 0);
        abort_req = 1'b0;
        send_frame(2, 8'h5A, 1);
        settle();
        check(last_len == 4 && expq.size() == 0, "R10", last_len, 4);

        // Mid-frame abort with draining.
        sb_en = 1'b0;
        e0 = err_cnt;
        fork
            send_frame(5, 8'h81, 0);
            begin
                @(negedge clk);
                while (!tx_en) @(negedge clk);
                repeat (2) @(negedge clk);
                abort_req = 1'b1;
                @(negedge clk);
                abort_req = 1'b0;
            end
        join
        settle();
        check(err_cnt - e0 == 1, "R5", err_cnt - e0, 1);
        check(en_after_err == 0, "R5", en_after_err, 0);
        check(last_len < 10, "R6", last_len, 4);
        expq.delete();
        sb_en = 1'b1;
        send_frame(3, 8'h29, 1);
        settle();
        check(last_len == 6 && expq.size() == 0, "R6", last_len, 6);

        // Abort on a one-byte frame as its end marker is taken.
        sb_en = 1'b0;
        e0 = err_cnt;
        fork
            send_byte(8'hC3, 1'b1, 1'b0);
            begin
                @(negedge clk);
                while (!tx_en) @(negedge clk);
                abort_req = 1'b1;
                @(negedge clk);
                abort_req = 1'b0;
            end
        join
        settle();
        check(err_cnt - e0 == 1, "R5", err_cnt - e0, 1);
        expq.delete();
        sb_en = 1'b1;
        send_frame(2, 8'h74, 1);
        settle();
        check(last_len == 4 && expq.size() == 0, "R6", last_len, 4);

        // Underrun after a non-final byte.
        sb_en = 1'b0;
        e0 = err_cnt;
        send_byte(8'h66, 1'b0, 1'b0);
        repeat (6) @(negedge clk);
        check(err_cnt - e0 == 1, "R7", err_cnt - e0, 1);
        n0 = en_total;
        send_byte(8'h11, 1'b0, 1'b0);
        send_byte(8'h22, 1'b1, 1'b0);
        settle();
        check(en_total == n0, "R7", en_total - n0, 0);
        expq.delete();
        sb_en = 1'b1;
        send_frame(2, 8'h9E, 1);
        settle();
        check(last_len == 4 && expq.size() == 0, "R7", last_len, 4);

        // Low-power idle while quiet.
        lpi_req = 1'b1;
        repeat (2) @(negedge clk);
        check(!tx_en && tx_er && txd == 4'b0001, "R8", {tx_en, tx_er, txd}, 6'b010001);
        repeat (5) @(negedge clk);
        check(!tx_en && tx_er && txd == 4'b0001, "R8", {tx_en, tx_er, txd}, 6'b010001);

        // A waiting frame is held off by the request.
        fork
            send_frame(2, 8'h4B, 1);
            begin
                repeat (6) @(negedge clk);
                check(!tx_en && !in_ready, "R9", {tx_en, in_ready}, 0);
                lpi_req = 1'b0;
            end
        join
        settle();
        check(last_len == 4 && expq.size() == 0, "R9", last_len, 4);
        check(!tx_er, "R10", tx_er, 0);

        // Request raised mid-frame waits for frame end plus a quiet cycle.
        fork
            send_frame(4, 8'h0F, 1);
            begin
                @(negedge clk);
                while (!tx_en) @(negedge clk);
                lpi_req = 1'b1;
            end
        join
        settle();
        check(last_len == 8 && expq.size() == 0, "R9", last_len, 8);
        check(!tx_en && tx_er && txd == 4'b0001, "R8", {tx_en, tx_er, txd}, 6'b010001);
        check(lpi_viol == 0, "R9", lpi_viol, 0);
        lpi_req = 1'b0;
        repeat (2) @(negedge clk);
        check(!tx_er && !tx_en, "R10", {tx_en, tx_er}, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=0", 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule